// File: doc/BRIEF.md
# Byte-Serial AES-128 Round-Key Generator

This block derives the AES-128 encryption key schedule one byte per clock while holding only a single round key. The 16 cipher-key bytes enter serially through an 8-bit port. After that, each asserted step cycle computes one byte of the next round key, so a complete round key takes 16 steps and all ten round keys take 160 steps. A single 16-stage byte chain stores the key. The word rotation, the S-box substitution and the round constant are applied at fixed chain taps during the first four steps of a round. The remaining twelve steps only XOR a byte with the byte produced four steps earlier.

Two byte streams leave the block. The undelayed stream carries the byte entering the chain in the current cycle: a cipher-key byte while loading, or a freshly computed round-key byte while stepping. A cipher datapath uses it for the last round. The second stream is the same bytes four clock cycles later. It suits the regular rounds and the initial key addition, where a four-cycle column operation sits between the key and its use. Computed keys replace the cipher key in the chain, so the key must be loaded again for every block. A load may begin on the cycle after the last step of the previous block.

Top module: `ake_key_expander`

## Requirements
- R1: After reset, `last_rk_o` and `dly_rk_o` read 00, and `step_i` has no effect until a key load has started.
- R2: While `load_i` is high, `key_byte_i` enters the chain and appears on `last_rk_o` in the same cycle. Sixteen loads place cipher-key byte 0 first. A load restarts the schedule at round 1, byte 0, and takes priority over `step_i`.
- R3: Each step cycle of round r (1 to 10) puts byte j of round key r on `last_rk_o`, with j counting 0 to 15 through the round. Byte 4w+i is byte i of word w, the byte order of the standard key schedule.
- R4: For j from 0 to 3, byte j equals byte j of the previous key XOR the S-box image of byte 12+((j+1) mod 4) of the previous key. For j from 4 to 15, byte j equals byte j of the previous key XOR new byte j-4.
- R5: Byte 0 of round r is additionally XORed with a round constant: 01, 02, 04, 08, 10, 20, 40 and 80 for rounds 1 to 8, then 1B and 36 for rounds 9 and 10. The constant is zero for every other byte.
- R6: After 160 steps, further steps have no effect and `last_rk_o` reads 00 until the next load.
- R7: A cycle with neither `load_i` nor `step_i` holds the schedule position, so the following step resumes with the next byte, and `last_rk_o` reads 00 in that cycle.
- R8: `dly_rk_o` equals the value `last_rk_o` had four clock cycles earlier, counting idle cycles.
- R9: A load that starts in the middle of an expansion abandons it. The newly loaded key is then expanded from round 1.
- R10: For cipher key 2b7e151628aed2a6abf7158809cf4f3c, round key 1 is a0fafe1788542cb123a339392a6c7605 and round key 10 is d014f9a8c9ee2589e13f0cc8b6630ca6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Shift one cipher-key byte into the chain |
| key_byte_i | input | 8 | Cipher-key byte, byte 0 first |
| step_i | input | 1 | Compute the next round-key byte |
| last_rk_o | output | 8 | Byte entering the chain this cycle (00 when idle) |
| dly_rk_o | output | 8 | `last_rk_o` delayed by four clock cycles |

## Verification
A wrong tap, S-box image or round constant corrupts one byte of round key 1, and every later round propagates the error through the XOR feedback. The fault therefore shows on `last_rk_o` within at most 16 steps, and on `dly_rk_o` four cycles after that. A byte-counter or round-counter fault shifts the round-constant position or the S-box steps, which shows as mismatches at the start of a round. Pauses, mid-expansion reloads and steps past round 10 expose a position counter that advances on the wrong cycles, because the next byte then no longer matches the model.

// File: rtl/ake_pkg.sv
package ake_pkg;

    typedef logic [7:0] byte_t;

    // Product in GF(2^8) modulo x^8 + x^4 + x^3 + x + 1
    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t p;
        byte_t aa;
        p  = '0;
        aa = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ aa;
            aa = {aa[6:0], 1'b0} ^ (aa[7] ? 8'h1b : 8'h00);
        end
        return p;
    endfunction

    function automatic byte_t xtime(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

endpackage

// File: rtl/ake_sbox.sv
module ake_sbox
    import ake_pkg::*;
(
    input  logic [7:0] x_i,
    output logic [7:0] y_o
);
    byte_t sq;
    byte_t inv;

    // inverse as x^254 = x^2 * x^4 * ... * x^128 (zero maps to zero)
    always_comb begin
        sq  = x_i;
        inv = 8'h01;
        for (int k = 0; k < 7; k++) begin
            sq  = gf_mul(sq, sq);
            inv = gf_mul(inv, sq);
        end
        y_o = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                  ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    end
endmodule

// File: rtl/ake_rcon.sv
module ake_rcon
    import ake_pkg::*;
#(
    parameter int NROUNDS = 10,
    parameter int RW      = 4
) (
    input  logic [RW-1:0] rnd_i,
    input  logic          en_i,
    output logic [7:0]    rcon_o
);
    byte_t v;

    always_comb begin
        v = 8'h01;
        for (int k = 2; k <= NROUNDS; k++) begin
            if (RW'(k) <= rnd_i) v = xtime(v);
        end
        rcon_o = (en_i && rnd_i >= RW'(1) && rnd_i <= RW'(NROUNDS)) ? v : 8'h00;
    end
endmodule

// File: rtl/ake_delay.sv
module ake_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);
    if (DEPTH == 0) begin : g_wire
        assign dout_o = din_i;
    end else begin : g_line
        logic [W-1:0] line_d [DEPTH];
        logic [W-1:0] line_q [DEPTH];

        always_comb begin
            line_d[0] = din_i;
            for (int i = 1; i < DEPTH; i++) line_d[i] = line_q[i-1];
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
            end else begin
                for (int i = 0; i < DEPTH; i++) line_q[i] <= line_d[i];
            end
        end

        assign dout_o = line_q[DEPTH-1];
    end
endmodule

// File: rtl/ake_key_expander.sv
module ake_key_expander
    import ake_pkg::*;
#(
    parameter int NROUNDS   = 10,
    parameter int KEY_BYTES = 16,
    parameter int LAG       = 4
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       load_i,
    input  logic [7:0] key_byte_i,
    input  logic       step_i,
    output logic [7:0] last_rk_o,
    output logic [7:0] dly_rk_o
);
    localparam int WORD    = 4;
    localparam int CW      = $clog2(KEY_BYTES);
    localparam int RW      = $clog2(NROUNDS + 2);
    // Chain head q[0] holds the byte consumed this cycle; new bytes enter at the top.
    localparam int FB_TAP  = KEY_BYTES - WORD;         // new byte four steps back
    localparam int SB_TAP  = KEY_BYTES - WORD + 1;     // rotated word, steps 0..2
    localparam int ALT_TAP = KEY_BYTES - 2*WORD + 1;   // rotated word, step 3
    localparam logic [RW-1:0] RND_DONE = RW'(NROUNDS + 1);

    typedef struct packed {
        logic [KEY_BYTES-1:0][7:0] chain;
        logic [CW-1:0]             bcnt;
        logic [RW-1:0]             rnd;
    } state_t;

    state_t s_d, s_q;

    logic  busy;
    logic  step_go;
    logic  rcon_en;
    byte_t sb_in, sb_out, rcon_w, new_b, shift_in;

    assign busy    = (s_q.rnd <= RW'(NROUNDS));
    assign step_go = step_i && !load_i && busy;
    assign rcon_en = step_go && (s_q.bcnt == '0);

    ake_sbox i_sbox (
        .x_i (sb_in),
        .y_o (sb_out)
    );

    ake_rcon #(.NROUNDS(NROUNDS), .RW(RW)) i_rcon (
        .rnd_i  (s_q.rnd),
        .en_i   (rcon_en),
        .rcon_o (rcon_w)
    );

    always_comb begin
        sb_in = (s_q.bcnt == CW'(WORD - 1)) ? s_q.chain[ALT_TAP] : s_q.chain[SB_TAP];
        if (s_q.bcnt < CW'(WORD)) new_b = s_q.chain[0] ^ sb_out ^ rcon_w;
        else                      new_b = s_q.chain[0] ^ s_q.chain[FB_TAP];
        shift_in  = load_i ? key_byte_i : new_b;
        last_rk_o = (load_i || step_go) ? shift_in : 8'h00;

        s_d = s_q;
        if (load_i || step_go) begin
            for (int i = 0; i < KEY_BYTES - 1; i++) s_d.chain[i] = s_q.chain[i+1];
            s_d.chain[KEY_BYTES-1] = shift_in;
        end
        if (load_i) begin
            s_d.bcnt = '0;
            s_d.rnd  = RW'(1);
        end else if (step_go) begin
            if (s_q.bcnt == CW'(KEY_BYTES - 1)) begin
                s_d.bcnt = '0;
                s_d.rnd  = s_q.rnd + RW'(1);
            end else begin
                s_d.bcnt = s_q.bcnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.chain <= '0;
            s_q.bcnt  <= '0;
            s_q.rnd   <= RND_DONE;
        end else begin
            s_q <= s_d;
        end
    end

    ake_delay #(.W(8), .DEPTH(LAG)) i_lag (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .din_i  (last_rk_o),
        .dout_o (dly_rk_o)
    );

    // R2: a load always restarts at round 1, byte 0
    a_r2_load_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (s_q.bcnt == '0 && s_q.rnd == RW'(1)));

    // R6: round counter stays in 1..NROUNDS+1
    a_r6_rnd_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.rnd >= RW'(1) && s_q.rnd <= RND_DONE));

    // R6: once finished, steps leave the chain untouched
    a_r6_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy && !load_i) |=> $stable(s_q.chain));

    // R7: an idle cycle keeps position and contents
    a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !step_i) |=> ($stable(s_q.chain) && $stable(s_q.bcnt) && $stable(s_q.rnd)));

    // R5: the constant applied at byte 0 of rounds 1..8 is a single bit
    a_r5_rcon_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rcon_en && s_q.rnd <= RW'(8)) |-> $onehot(rcon_w));

    // R3: the step after the last byte of a round begins the next round
    a_r3_round_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_go && s_q.bcnt == CW'(KEY_BYTES - 1)) |=> (s_q.bcnt == '0 && s_q.rnd == $past(s_q.rnd) + RW'(1)));
endmodule

// File: tb/test_ake_key_expander.sv
module test_ake_key_expander;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load = 1'b0;
    logic [7:0] key_byte = 8'h00;
    logic       step = 1'b0;
    logic [7:0] last_rk;
    logic [7:0] dly_rk;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0] sbx  [256];
    logic [7:0] kbuf [16];
    logic [7:0] rk   [0:10][0:15];
    logic [7:0] obs  [0:10][0:15];
    logic [7:0] hist [4];
    logic [7:0] seen;

    ake_key_expander i_ake_key_expander (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .load_i     (load),
        .key_byte_i (key_byte),
        .step_i     (step),
        .last_rk_o  (last_rk),
        .dly_rk_o   (dly_rk)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pmul(input logic [7:0] a, input logic [7:0] b);
        logic [14:0] p;
        p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (15'(a) << i);
        for (int k = 14; k >= 8; k--) if (p[k]) p = p ^ (15'h11b << (k - 8));
        return p[7:0];
    endfunction

    task automatic build_sbox();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] v, s, c;
            v = 8'h00;
            c = 8'h63;
            for (int y = 1; y < 256; y++) if (pmul(8'(x), 8'(y)) == 8'h01) v = 8'(y);
            for (int i = 0; i < 8; i++)
                s[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8] ^ c[i];
            sbx[x] = s;
        end
    endtask

    task automatic model_expand();
        logic [7:0] rc;
        rc = 8'h01;
        for (int j = 0; j < 16; j++) rk[0][j] = kbuf[j];
        for (int r = 1; r <= 10; r++) begin
            for (int j = 0; j < 16; j++) begin
                if (j < 4) rk[r][j] = rk[r-1][j] ^ sbx[rk[r-1][12 + ((j+1)%4)]] ^ ((j == 0) ? rc : 8'h00);
                else       rk[r][j] = rk[r-1][j] ^ rk[r][j-4];
            end
            rc = (rc[7]) ? ((rc << 1) ^ 8'h1b) : (rc << 1);
        end
    endtask

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one clock cycle, entered and left just after a falling edge
    task automatic cyc(input logic ld, input logic [7:0] kb, input logic st,
                       input logic [7:0] exp, input string tag);
        load = ld; key_byte = kb; step = st;
        #1;
        seen = last_rk;
        check(last_rk == exp, tag, 128'(last_rk), 128'(exp));
        check(dly_rk == hist[3], "R8", 128'(dly_rk), 128'(hist[3]));
        hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = exp;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_key(input bit with_step);
        for (int i = 0; i < 16; i++) cyc(1'b1, kbuf[i], with_step, kbuf[i], "R2");
        model_expand();
    endtask

    task automatic expand(input int upto, input bit pause, input string tag);
        for (int r = 1; r <= upto; r++) begin
            for (int t = 0; t < 16; t++) begin
                if (pause && r == 3 && (t % 5) == 2) cyc(1'b0, 8'h00, 1'b0, 8'h00, "R7");
                cyc(1'b0, 8'h00, 1'b1, rk[r][t], (t == 0) ? "R5" : (t < 4) ? "R4" : tag);
                obs[r][t] = seen;
            end
        end
    endtask

    function automatic logic [127:0] obs_word(input int r);
        logic [127:0] w;
        for (int j = 0; j < 16; j++) w[127-8*j -: 8] = obs[r][j];
        return w;
    endfunction

    task automatic set_key(input logic [127:0] k);
        for (int i = 0; i < 16; i++) kbuf[i] = k[127-8*i -: 8];
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] lcg;
        for (int i = 0; i < 4; i++) hist[i] = 8'h00;
        build_sbox();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(last_rk == 8'h00, "R1", 128'(last_rk), 128'h0);
        check(dly_rk == 8'h00, "R1", 128'(dly_rk), 128'h0);
        @(negedge clk);
        // R1: steps without a loaded key do nothing
        for (int i = 0; i < 3; i++) cyc(1'b0, 8'h00, 1'b1, 8'h00, "R1");

        // known vector with pauses in round 3
        set_key(128'h2b7e151628aed2a6abf7158809cf4f3c);
        load_key(1'b0);
        expand(10, 1'b1, "R3");
        check(obs_word(1) == 128'ha0fafe1788542cb123a339392a6c7605, "R10", obs_word(1),
              128'ha0fafe1788542cb123a339392a6c7605);
        check(obs_word(10) == 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R10", obs_word(10),
              128'hd014f9a8c9ee2589e13f0cc8b6630ca6);

        // R6: steps past round 10 are ignored
        for (int i = 0; i < 5; i++) cyc(1'b0, 8'h00, 1'b1, 8'h00, "R6");
        // R7: idle cycles
        for (int i = 0; i < 2; i++) cyc(1'b0, 8'h00, 1'b0, 8'h00, "R7");

        // R2: load wins over step; all-zero key
        set_key(128'h0);
        load_key(1'b1);
        expand(2, 1'b0, "R3");
        check(obs_word(1) == 128'h62636363626363636263636362636363, "R4", obs_word(1),
              128'h62636363626363636263636362636363);
        for (int t = 0; t < 5; t++) cyc(1'b0, 8'h00, 1'b1, rk[3][t], "R3");

        // R9: reload in the middle of an expansion
        set_key(128'h000102030405060708090a0b0c0d0e0f);
        load_key(1'b0);
        expand(10, 1'b0, "R9");

        // back-to-back pseudo-random keys, load right after the last step
        lcg = 32'h1234_5678;
        for (int n = 0; n < 6; n++) begin
            for (int i = 0; i < 16; i++) begin
                lcg = lcg * 32'd1664525 + 32'd1013904223;
                kbuf[i] = lcg[23:16];
            end
            load_key(1'b0);
            expand(10, (n % 2) == 1, "R3");
        end
        for (int i = 0; i < 5; i++) cyc(1'b0, 8'h00, 1'b0, 8'h00, "R7");
        finish_run();
    end
endmodule